// File: doc/BRIEF.md
# Dual Process Watchdog Unit

This block supervises two activities with a pair of watchdogs driven by one shared prescaler. The prescaler counts pulses of a 25 MHz reference tick, given to the block as a one-cycle enable strobe, and emits one base cycle every (divider + 2) ticks. One watchdog guards the local host interface and is reloaded by a host-access strobe. The other guards process-data exchange and is reloaded by a trigger strobe from the buffer logic.

The network side programs the divider and both watchdog times through a small write port that carries a register selector. A write to a counter selector clears that expiry counter. Each watchdog reports a status bit and has a saturating expiry counter. A process-data expiry also raises an event flag, and the host clears that flag when it reads the process-data status.

Top module: `dual_watchdog_unit`

## Requirements
- R1: After reset the divider reads 2498, both watchdog times read 1000, both status bits read 1, both expiry counters read 0 and the event flag reads 0.
- R2: Selector 0 writes the divider from the low 13 data bits and restarts the prescaler. After that, one base cycle completes every (divider + 2) reference ticks.
- R3: A watchdog with a nonzero time T expires on the T-th base cycle after its last reload. Its status bit (1 = active or disabled, 0 = expired) reads 0 from the next clock cycle on.
- R4: The host-access strobe reloads the host watchdog and the process-data trigger strobe reloads the process-data watchdog. A reload restarts the count from the programmed time and sets the status back to 1.
- R5: A time of 0 disables its watchdog. The status reads 1 and the watchdog never expires, whatever ticks arrive.
- R6: Each 8-bit expiry counter adds one on every expiry of its watchdog and stops at 255.
- R7: An expiry counter adds one when a write of 0 disables its running watchdog. A write of 0 to a watchdog that is already disabled changes nothing.
- R8: A network write with selector 3 clears the host expiry counter, and a write with selector 4 clears the process-data expiry counter. The other counter keeps its value.
- R9: A process-data expiry sets the event flag. A host-side status read clears it. If an expiry and a read fall in the same cycle, the flag stays set.
- R10: Selector 1 writes the host time and selector 2 writes the process-data time. A new time written while a watchdog runs replaces the count at the next base-cycle boundary. That boundary does not count down.
- R11: Writes with selectors 5 to 7 change no register, counter or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per 25 MHz reference tick |
| net_we | input | 1 | Network-side write strobe |
| net_sel | input | 3 | Register selector for the write |
| net_wdata | input | DATA_W | Write data |
| host_pd_stat_rd | input | 1 | Host-side read of the process-data status |
| host_kick | input | 1 | Host-access strobe, reloads the host watchdog |
| pd_kick | input | 1 | Process-data trigger strobe, reloads the process-data watchdog |
| host_ok | output | 1 | Host watchdog status: 1 active/disabled, 0 expired |
| pd_ok | output | 1 | Process-data watchdog status: 1 active/disabled, 0 expired |
| host_exp_cnt | output | CNT_W | Host expiry counter |
| pd_exp_cnt | output | CNT_W | Process-data expiry counter |
| pd_exp_evt | output | 1 | Process-data expiry event flag |
| cfg_div | output | DIV_W | Current divider value |
| cfg_host_time | output | TIME_W | Current host watchdog time |
| cfg_pd_time | output | TIME_W | Current process-data watchdog time |

## Verification
A reference tick that ends a base cycle decrements or expires a watchdog at the next rising edge. The status, counter and event outputs therefore change one clock after the tick strobe. Writes, reloads, counter clears and host reads also take effect one clock after their strobe. Every stimulus task drives its strobe for one full cycle, from falling edge to falling edge, and samples at the falling edge that follows, so each check lands exactly one clock after the causing edge. The expected expiry points are worked out in ticks as T·(divider + 2), counted from a prescaler restart or a reload.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
  typedef enum logic [2:0] {
    SEL_DIV   = 3'd0,
    SEL_HTIME = 3'd1,
    SEL_PTIME = 3'd2,
    SEL_HCLR  = 3'd3,
    SEL_PCLR  = 3'd4
  } wdu_sel_e;

  localparam int unsigned NUM_WD = 2;
  localparam int unsigned WD_HOST = 0;
  localparam int unsigned WD_PD   = 1;
endpackage

// File: rtl/wdu_prescaler.sv
module wdu_prescaler #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             base
);
  localparam int unsigned PC_W = DIV_W + 1;

  // index of the last tick in a base cycle: a cycle spans div + 2 ticks
  function automatic logic [PC_W-1:0] last_index(input logic [DIV_W-1:0] d);
    return {1'b0, d} + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc;
  logic            at_end;

  assign at_end = tick && (pc == last_index(div));
  assign base   = at_end && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc <= '0;
    else if (restart) pc <= '0;
    else if (at_end)  pc <= '0;
    else if (tick)    pc <= pc + PC_W'(1);
  end
endmodule

// File: rtl/wdu_chan.sv
module wdu_chan #(
  parameter int unsigned TIME_W   = 16,
  parameter int unsigned TIME_RST = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base,
  input  logic              kick,
  input  logic              wr,
  input  logic [TIME_W-1:0] wdata,
  output logic [TIME_W-1:0] time_q,
  output logic              ok,
  output logic              expire,
  output logic              disable_ev
);
  logic [TIME_W-1:0] rem;
  logic              expired;
  logic              pend;
  logic              enabled;

  function automatic logic last_step(input logic [TIME_W-1:0] r);
    return r <= TIME_W'(1);
  endfunction

  assign enabled    = (time_q != '0);
  assign expire     = enabled && !kick && base && !pend && !expired && last_step(rem);
  assign disable_ev = wr && (wdata == '0) && enabled;
  assign ok         = !expired || !enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= TIME_W'(TIME_RST);
      rem     <= TIME_W'(TIME_RST);
      expired <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr) time_q <= wdata;

      if (wr)                          pend <= 1'b1;
      else if (enabled && (kick || base)) pend <= 1'b0;

      if (!enabled) begin
        rem     <= '0;
        expired <= 1'b0;
      end else if (kick) begin
        rem     <= time_q;
        expired <= 1'b0;
      end else if (base && pend) begin
        rem <= time_q;
      end else if (expire) begin
        rem     <= '0;
        expired <= 1'b1;
      end else if (base && !expired) begin
        rem <= rem - TIME_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdu_sat_cnt.sv
module wdu_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == '1) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= sat_inc(q);
  end
endmodule

// File: rtl/dual_watchdog_unit.sv
module dual_watchdog_unit
  import wdu_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DIV_W    = 13,
  parameter int unsigned TIME_W   = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DIV_RST  = 2498,
  parameter int unsigned TIME_RST = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              net_we,
  input  logic [2:0]        net_sel,
  input  logic [DATA_W-1:0] net_wdata,
  input  logic              host_pd_stat_rd,
  input  logic              host_kick,
  input  logic              pd_kick,
  output logic              host_ok,
  output logic              pd_ok,
  output logic [CNT_W-1:0]  host_exp_cnt,
  output logic [CNT_W-1:0]  pd_exp_cnt,
  output logic              pd_exp_evt,
  output logic [DIV_W-1:0]  cfg_div,
  output logic [TIME_W-1:0] cfg_host_time,
  output logic [TIME_W-1:0] cfg_pd_time
);
  // named internal events, observed by the bound checker
  logic div_wr;
  logic base_cycle;
  logic host_expire, pd_expire;
  logic host_disable, pd_disable;
  logic host_cnt_clr, pd_cnt_clr;

  logic [NUM_WD-1:0]              kick_v, wr_v, ok_v, exp_v, dis_v, clr_v;
  logic [NUM_WD-1:0][TIME_W-1:0]  time_v;
  logic [NUM_WD-1:0][CNT_W-1:0]   cnt_v;
  logic [TIME_W-1:0]              time_wdata;

  assign div_wr     = net_we && (net_sel == SEL_DIV);
  assign time_wdata = TIME_W'(net_wdata);

  assign kick_v[WD_HOST] = host_kick;
  assign kick_v[WD_PD]   = pd_kick;
  assign wr_v[WD_HOST]   = net_we && (net_sel == SEL_HTIME);
  assign wr_v[WD_PD]     = net_we && (net_sel == SEL_PTIME);
  assign clr_v[WD_HOST]  = net_we && (net_sel == SEL_HCLR);
  assign clr_v[WD_PD]    = net_we && (net_sel == SEL_PCLR);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_div <= DIV_W'(DIV_RST);
    else if (div_wr) cfg_div <= net_wdata[DIV_W-1:0];
  end

  wdu_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ref_tick),
    .restart (div_wr),
    .div     (cfg_div),
    .base    (base_cycle)
  );

  for (genvar g = 0; g < NUM_WD; g++) begin : g_wd
    wdu_chan #(.TIME_W(TIME_W), .TIME_RST(TIME_RST)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .base       (base_cycle),
      .kick       (kick_v[g]),
      .wr         (wr_v[g]),
      .wdata      (time_wdata),
      .time_q     (time_v[g]),
      .ok         (ok_v[g]),
      .expire     (exp_v[g]),
      .disable_ev (dis_v[g])
    );

    wdu_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_v[g]),
      .inc   (exp_v[g] || dis_v[g]),
      .q     (cnt_v[g])
    );
  end

  assign host_expire   = exp_v[WD_HOST];
  assign pd_expire     = exp_v[WD_PD];
  assign host_disable  = dis_v[WD_HOST];
  assign pd_disable    = dis_v[WD_PD];
  assign host_cnt_clr  = clr_v[WD_HOST];
  assign pd_cnt_clr    = clr_v[WD_PD];

  assign host_ok       = ok_v[WD_HOST];
  assign pd_ok         = ok_v[WD_PD];
  assign host_exp_cnt  = cnt_v[WD_HOST];
  assign pd_exp_cnt    = cnt_v[WD_PD];
  assign cfg_host_time = time_v[WD_HOST];
  assign cfg_pd_time   = time_v[WD_PD];

  // expiry sets the flag; a host read clears it unless an expiry coincides
  always_ff @(posedge clk) begin
    if (!rst_n)               pd_exp_evt <= 1'b0;
    else if (pd_expire)       pd_exp_evt <= 1'b1;
    else if (host_pd_stat_rd) pd_exp_evt <= 1'b0;
  end
endmodule

// File: rtl/wdu_checker.sv
module wdu_checker #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_cycle,
  input logic              host_kick,
  input logic              pd_kick,
  input logic              host_expire,
  input logic              pd_expire,
  input logic              host_disable,
  input logic              host_cnt_clr,
  input logic              pd_cnt_clr,
  input logic              host_pd_stat_rd,
  input logic              host_ok,
  input logic              pd_ok,
  input logic [CNT_W-1:0]  host_exp_cnt,
  input logic [CNT_W-1:0]  pd_exp_cnt,
  input logic              pd_exp_evt,
  input logic [TIME_W-1:0] cfg_host_time
);
  p_expire_on_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_expire || pd_expire) |-> base_cycle);

  p_expire_drops_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_expire && !host_kick) |=> !host_ok);

  p_reload_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_kick || pd_kick) |=> (host_ok && pd_ok) || $past(host_kick) != $past(pd_kick) || host_ok || pd_ok);

  p_host_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_kick |=> host_ok);

  p_pd_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pd_kick |=> pd_ok);

  p_disabled_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_host_time == '0) |-> host_ok);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cnt_clr |=> (host_exp_cnt == $past(host_exp_cnt)) ||
                      (host_exp_cnt == $past(host_exp_cnt) + CNT_W'(1)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exp_cnt == '1 && !pd_cnt_clr) |=> pd_exp_cnt == '1);

  p_disable_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_disable && !host_cnt_clr && host_exp_cnt != '1) |=>
      host_exp_cnt == $past(host_exp_cnt) + CNT_W'(1));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_cnt_clr |=> host_exp_cnt == '0);

  p_evt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_expire |=> pd_exp_evt);

  p_evt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pd_stat_rd && !pd_expire) |=> !pd_exp_evt);
endmodule

bind dual_watchdog_unit wdu_checker #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .base_cycle      (base_cycle),
  .host_kick       (host_kick),
  .pd_kick         (pd_kick),
  .host_expire     (host_expire),
  .pd_expire       (pd_expire),
  .host_disable    (host_disable),
  .host_cnt_clr    (host_cnt_clr),
  .pd_cnt_clr      (pd_cnt_clr),
  .host_pd_stat_rd (host_pd_stat_rd),
  .host_ok         (host_ok),
  .pd_ok           (pd_ok),
  .host_exp_cnt    (host_exp_cnt),
  .pd_exp_cnt      (pd_exp_cnt),
  .pd_exp_evt      (pd_exp_evt),
  .cfg_host_time   (cfg_host_time)
);

// File: tb/dual_watchdog_unit_tb.sv
module dual_watchdog_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        net_we = 1'b0;
  logic [2:0]  net_sel = 3'd0;
  logic [15:0] net_wdata = 16'd0;
  logic        host_pd_stat_rd = 1'b0;
  logic        host_kick = 1'b0;
  logic        pd_kick = 1'b0;
  logic        host_ok, pd_ok, pd_exp_evt;
  logic [7:0]  host_exp_cnt, pd_exp_cnt;
  logic [12:0] cfg_div;
  logic [15:0] cfg_host_time, cfg_pd_time;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_watchdog_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .net_we(net_we),
    .net_sel(net_sel), .net_wdata(net_wdata), .host_pd_stat_rd(host_pd_stat_rd),
    .host_kick(host_kick), .pd_kick(pd_kick), .host_ok(host_ok), .pd_ok(pd_ok),
    .host_exp_cnt(host_exp_cnt), .pd_exp_cnt(pd_exp_cnt), .pd_exp_evt(pd_exp_evt),
    .cfg_div(cfg_div), .cfg_host_time(cfg_host_time), .cfg_pd_time(cfg_pd_time)
  );

  task automatic check(input string what, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk); net_we = 1'b1; net_sel = sel; net_wdata = d;
    @(negedge clk); net_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic kick_host();
    @(negedge clk); host_kick = 1'b1;
    @(negedge clk); host_kick = 1'b0;
  endtask

  task automatic kick_pd();
    @(negedge clk); pd_kick = 1'b1;
    @(negedge clk); pd_kick = 1'b0;
  endtask

  task automatic t_reset_r1();
    check("R1 divider", int'(cfg_div), 2498);
    check("R1 host time", int'(cfg_host_time), 1000);
    check("R1 pd time", int'(cfg_pd_time), 1000);
    check("R1 status", int'({host_ok, pd_ok}), 3);
    check("R1 counters", int'(host_exp_cnt) + int'(pd_exp_cnt), 0);
    check("R1 event", int'(pd_exp_evt), 0);
  endtask

  // host time 3, 2 ticks per base cycle: expiry on tick 6
  task automatic t_host_expiry_r3();
    wr(3'd0, 16'hFFFF);
    check("R2 divider masked to 13 bits", int'(cfg_div), 8191);
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd0);
    wr(3'd1, 16'd3);
    check("R10 host time written", int'(cfg_host_time), 3);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    kick_host();
    ticks(5);
    check("R3 host still active at tick 5", int'(host_ok), 1);
    ticks(1);
    check("R3 host expired at tick 6", int'(host_ok), 0);
    check("R6 host counter after expiry", int'(host_exp_cnt), 1);
    ticks(10);
    check("R6 no re-expiry while expired", int'(host_exp_cnt), 1);
    kick_host();
    check("R4 host reload restores status", int'(host_ok), 1);
  endtask

  // pd time 4, divider 1 (3 ticks per base): expiry on tick 12
  task automatic t_pd_expiry_r9();
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    kick_pd();
    ticks(11);
    check("R3 pd active at tick 11", int'(pd_ok), 1);
    check("R9 event clear before expiry", int'(pd_exp_evt), 0);
    ticks(1);
    check("R3 pd expired at tick 12", int'(pd_ok), 0);
    check("R9 event set on expiry", int'(pd_exp_evt), 1);
    check("R6 pd counter", int'(pd_exp_cnt), 1);
    @(negedge clk); host_pd_stat_rd = 1'b1;
    @(negedge clk); host_pd_stat_rd = 1'b0;
    check("R9 host read clears event", int'(pd_exp_evt), 0);
    check("R9 read leaves status", int'(pd_ok), 0);
    kick_pd();
    check("R4 pd reload restores status", int'(pd_ok), 1);
    // expiry and host read in the same cycle: flag stays set
    wr(3'd0, 16'd0);
    wr(3'd2, 16'd2);
    kick_pd();
    ticks(3);
    @(negedge clk); ref_tick = 1'b1; host_pd_stat_rd = 1'b1;
    @(negedge clk); ref_tick = 1'b0; host_pd_stat_rd = 1'b0;
    check("R9 expiry beats simultaneous read", int'(pd_exp_evt), 1);
  endtask

  task automatic t_saturate_r6();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd1);
    wr(3'd3, 16'd0);
    for (int i = 0; i < 260; i++) begin
      kick_host();
      ticks(2);
      if (i == 2) check("R6 counter counts 3", int'(host_exp_cnt), 3);
    end
    check("R6 counter saturates at 255", int'(host_exp_cnt), 255);
  endtask

  task automatic t_clear_r8();
    int pd_before;
    pd_before = int'(pd_exp_cnt);
    wr(3'd3, 16'h1234);
    check("R8 host counter cleared", int'(host_exp_cnt), 0);
    check("R8 pd counter kept", int'(pd_exp_cnt), pd_before);
  endtask

  task automatic t_disable_r7();
    wr(3'd3, 16'd0);
    wr(3'd1, 16'd0);
    check("R7 disable counts once", int'(host_exp_cnt), 1);
    wr(3'd1, 16'd0);
    check("R7 second zero write no count", int'(host_exp_cnt), 1);
    ticks(12);
    check("R5 disabled never expires", int'(host_ok), 1);
    check("R5 disabled counter idle", int'(host_exp_cnt), 1);
  endtask

  // host time 5 then 2 mid-run, divider 0
  task automatic t_rewrite_r10();
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd5);
    wr(3'd3, 16'd0);
    kick_host();
    ticks(1);
    wr(3'd1, 16'd2);
    ticks(4);
    check("R10 new time not yet expired", int'(host_ok), 1);
    ticks(1);
    check("R10 new time expires at boundary+2", int'(host_ok), 0);
  endtask

  task automatic t_ignored_r11();
    int c_h, c_p;
    c_h = int'(host_exp_cnt);
    c_p = int'(pd_exp_cnt);
    wr(3'd5, 16'd0);
    wr(3'd6, 16'd7);
    wr(3'd7, 16'hFFFF);
    check("R11 divider unchanged", int'(cfg_div), 0);
    check("R11 host time unchanged", int'(cfg_host_time), 2);
    check("R11 pd time unchanged", int'(cfg_pd_time), 2);
    check("R11 counters unchanged", c_h * 256 + c_p, int'(host_exp_cnt) * 256 + int'(pd_exp_cnt));
    check("R11 status unchanged", int'(host_ok), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_host_expiry_r3();
    t_pd_expiry_r9();
    t_saturate_r6();
    t_clear_r8();
    t_disable_r7();
    t_rewrite_r10();
    t_ignored_r11();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule